// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is a byte-wide serial port with two line disciplines chosen by a mode input. In asynchronous mode it sends standard start/data/stop frames on the transmit pin and receives them on the receive pin. Bit timing comes from a baud tick that an external reload timer supplies at sixteen times the bit rate. The receiver oversamples the line and takes one sample at the centre of each bit.

In clock-synchronous mode the transmit pin becomes a shift clock that the port drives as master. The receive pin becomes a bidirectional data line. Each transfer moves eight bits, least significant first, with one clock period of eight system clocks per bit. A transmit leaves the data line enabled and moves it well ahead of each rising clock edge. A receive releases the line and samples it on each rising edge.

Received bytes from either mode go into one holding register, which has a ready flag and an overrun flag. The host writes a byte to start a transmit. In synchronous mode it pulses a request to start a receive, and it reads bytes with a read strobe.

Top module: `dual_serial_port`

## Requirements
- R1: After reset the transmit pin is high, the data-line enable is low, and the busy, ready and overrun flags are all low. Reset asserted at any time returns the port to this state at once.
- R2: In asynchronous mode a write sends one frame of ten bits. The frame is a low start bit, then eight data bits least significant first, then a high stop bit. Every bit after the start bit lasts exactly 16 baud ticks, and the line stays high when idle.
- R3: In asynchronous mode, a low level seen on a baud tick while idle begins a frame. The line is sampled on the 8th tick after that, and then every 16 ticks. A valid frame puts its eight data bits, least significant first, into the holding register and sets ready.
- R4: If the start bit reads high at its centre sample, the receiver returns to idle and nothing is delivered.
- R5: If the stop bit reads low, the byte is discarded, and neither the ready flag nor the holding register changes.
- R6: In synchronous mode a transfer puts out eight clock periods of 8 system clocks each. Each period has 4 low clocks and 4 high clocks, and the clock pin stays high whenever no transfer runs.
- R7: During a synchronous transmit, the data line carries the byte least significant bit first. Each bit changes 6 system clocks before the rising clock edge that samples it and stays unchanged for 2 clocks after that edge.
- R8: A receive request in synchronous mode runs the same eight clock periods with the data line released. The line is sampled on each rising clock edge, least significant bit first, and the resulting byte goes into the holding register with ready set.
- R9: The data-line enable is high only while a synchronous transmit is running.
- R10: If a byte completes while ready is still set and no read happens in that cycle, the port sets overrun and keeps the old byte. A read strobe clears both ready and overrun.
- R11: A write or receive request that arrives while the port is busy is ignored. A receive request in asynchronous mode is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 0 = asynchronous frames, 1 = clock-synchronous shifting |
| baud_tick | input | 1 | One-cycle pulse at 16x the asynchronous bit rate |
| tx_wr | input | 1 | Write strobe that starts a transmit of tx_data |
| tx_data | input | 8 | Byte to transmit |
| rx_req | input | 1 | Starts a synchronous receive (synchronous mode only) |
| rx_rd | input | 1 | Read strobe, clears ready and overrun |
| rx_data | output | 8 | Holding register for the received byte |
| rx_ready | output | 1 | Holding register holds an unread byte |
| rx_overrun | output | 1 | A byte was lost because the previous one was unread |
| busy | output | 1 | Asynchronous transmit or synchronous transfer in progress |
| txd_o | output | 1 | Serial data out (async) or shift clock out (sync) |
| rxd_i | input | 1 | Receive pin input value |
| rxd_o | output | 1 | Receive pin output value during synchronous transmit |
| rxd_oe | output | 1 | Output enable for the receive pin |

## Verification
The checker watches properties that hold on every cycle. The data-line enable appears only during a synchronous transmit. The clock pin is high whenever no transfer runs. Each low phase of the synchronous clock lasts exactly four cycles. Transmit data holds steady across the cycle after each rising edge. Overrun never shows without ready, and an unread byte stays put. Other behaviours depend on whole frames and can only be shown by the bench's scenarios. These include bit order, centre sampling against ticks, rejection of a false start, discard on a bad stop bit, the 8-clock period between rising edges, and writes dropped while busy.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } sp_dir_e;
endpackage

// File: rtl/sp_async_tx.sv
module sp_async_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int OVS_W   = $clog2(OVS);
  localparam int BC_W    = $clog2(FRAME_W + 1);
  localparam logic [OVS_W-1:0] TICK_LAST = OVS_W'(OVS - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [OVS_W-1:0]   tc_q, tc_d;
  logic [BC_W-1:0]    bc_q, bc_d;
  logic               busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    tc_d   = tc_q;
    bc_d   = bc_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        sh_d   = {1'b1, din, 1'b0};
        tc_d   = '0;
        bc_d   = BC_W'(FRAME_W);
        busy_d = 1'b1;
      end
    end else if (tick) begin
      if (tc_q == TICK_LAST) begin
        tc_d = '0;
        sh_d = {1'b1, sh_q[FRAME_W-1:1]};
        bc_d = bc_q - 1'b1;
        if (bc_q == BC_W'(1)) busy_d = 1'b0;
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tc_q   <= tc_d;
      bc_q   <= bc_d;
      busy_q <= busy_d;
    end
  end

  assign txd  = sh_q[0];
  assign busy = busy_q;
endmodule

// File: rtl/sp_async_rx.sv
module sp_async_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd_i,
  output logic              done,
  output logic [DATA_W-1:0] dout
);
  localparam int OVS_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [OVS_W-1:0] TICK_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] HALF_LAST = OVS_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_STOP  = IDX_W'(DATA_W + 1);

  logic              s1_q, s2_q;
  logic              act_q, act_d;
  logic [OVS_W-1:0]  tc_q, tc_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    act_d = act_q;
    tc_d  = tc_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    done  = 1'b0;
    if (!en) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (tick && !s2_q) begin
        act_d = 1'b1;
        tc_d  = '0;
        idx_d = '0;
      end
    end else if (tick) begin
      tc_d = (tc_q == TICK_LAST) ? '0 : tc_q + 1'b1;
      if (tc_q == HALF_LAST) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '0) begin
          if (s2_q) act_d = 1'b0;          // false start
        end else if (idx_q == IDX_STOP) begin
          act_d = 1'b0;
          done  = s2_q;                    // bad stop bit drops the byte
        end else begin
          sh_d = {s2_q, sh_q[DATA_W-1:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      act_q <= 1'b0;
      tc_q  <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      s1_q  <= rxd_i;
      s2_q  <= s1_q;
      act_q <= act_d;
      tc_q  <= tc_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign dout = sh_q;
endmodule

// File: rtl/sp_sync_shift.sv
module sp_sync_shift
  import sp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [DATA_W-1:0] din,
  input  logic              rxd_i,
  output logic              sclk,
  output logic              dout,
  output logic              oe,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  // SYNC_PERIOD must be a power of two so the phase counter wraps by itself
  localparam int PH_W  = $clog2(SYNC_PERIOD);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  LOW_FIRST = PH_W'(SYNC_PERIOD / 4);
  localparam logic [PH_W-1:0]  LOW_LAST  = PH_W'(SYNC_PERIOD / 4 + SYNC_PERIOD / 2 - 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(SYNC_PERIOD - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

  logic              act_q, act_d;
  sp_dir_e           dir_q, dir_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sclk_q, sclk_d;

  always_comb begin
    act_d = act_q;
    dir_d = dir_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    done  = 1'b0;
    if (!act_q) begin
      if (start_tx || start_rx) begin
        act_d = 1'b1;
        ph_d  = '0;
        bit_d = '0;
        dir_d = start_tx ? DIR_TX : DIR_RX;
        if (start_tx) sh_d = din;
      end
    end else begin
      ph_d = ph_q + 1'b1;
      // rising clock edge happens as the phase leaves LOW_LAST
      if (ph_q == LOW_LAST && dir_q == DIR_RX) sh_d = {rxd_i, sh_q[DATA_W-1:1]};
      if (ph_q == PH_LAST) begin
        if (bit_q == BIT_LAST) begin
          act_d = 1'b0;
          done  = (dir_q == DIR_RX);
        end else begin
          bit_d = bit_q + 1'b1;
          if (dir_q == DIR_TX) sh_d = {1'b0, sh_q[DATA_W-1:1]};
        end
      end
    end
    sclk_d = !(act_d && ph_d >= LOW_FIRST && ph_d <= LOW_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= DIR_RX;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b1;
    end else begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk   = sclk_q;
  assign dout   = sh_q[0];
  assign oe     = act_q && (dir_q == DIR_TX);
  assign active = act_q;
  assign rdata  = sh_q;
endmodule

// File: rtl/dual_serial_port.sv
module dual_serial_port #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              baud_tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_req,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun,
  output logic              busy,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rxd_o,
  output logic              rxd_oe
);
  logic              atx_txd, atx_busy;
  logic              arx_done;
  logic [DATA_W-1:0] arx_data;
  logic              syn_sclk, syn_dout, syn_oe, syn_act, syn_done;
  logic [DATA_W-1:0] syn_data;
  logic              idle;

  assign idle = !atx_busy && !syn_act;

  sp_async_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_atx (
    .clk(clk), .rst_n(rst_n),
    .start(tx_wr && !mode_sync && idle),
    .din(tx_data), .tick(baud_tick),
    .txd(atx_txd), .busy(atx_busy)
  );

  sp_async_rx #(.DATA_W(DATA_W), .OVS(OVS)) i_arx (
    .clk(clk), .rst_n(rst_n), .en(!mode_sync),
    .tick(baud_tick), .rxd_i(rxd_i),
    .done(arx_done), .dout(arx_data)
  );

  sp_sync_shift #(.DATA_W(DATA_W), .SYNC_PERIOD(SYNC_PERIOD)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .start_tx(tx_wr && mode_sync && idle),
    .start_rx(rx_req && mode_sync && idle),
    .din(tx_data), .rxd_i(rxd_i),
    .sclk(syn_sclk), .dout(syn_dout), .oe(syn_oe),
    .active(syn_act), .done(syn_done), .rdata(syn_data)
  );

  logic              rdy_q, rdy_d, ovr_q, ovr_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    dat_d = dat_q;
    if (rx_rd) begin
      rdy_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (arx_done || syn_done) begin
      if (rdy_q && !rx_rd) begin
        ovr_d = 1'b1;
      end else begin
        dat_d = syn_done ? syn_data : arx_data;
        rdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      dat_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      dat_q <= dat_d;
    end
  end

  assign rx_data    = dat_q;
  assign rx_ready   = rdy_q;
  assign rx_overrun = ovr_q;
  assign busy       = !idle;
  assign txd_o      = mode_sync ? syn_sclk : atx_txd;
  assign rxd_o      = syn_dout;
  assign rxd_oe     = syn_oe;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sync,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              rx_overrun,
  input logic              busy,
  input logic              txd_o,
  input logic              rxd_o,
  input logic              rxd_oe
);
  p_oe_sync_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (mode_sync && busy));

  p_async_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && !busy) |-> txd_o);

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && !busy) |-> txd_o);

  p_sclk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd_o) && mode_sync) |=> !txd_o ##1 !txd_o ##1 !txd_o ##1 txd_o);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txd_o) && rxd_oe) |=> $stable(rxd_o));

  p_overrun_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_ready);

  p_keep_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_rd) |=> ($stable(rx_data) && rx_ready));
endmodule

bind dual_serial_port sp_checker #(.DATA_W(DATA_W)) i_sp_checker (
  .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .rx_rd(rx_rd),
  .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
  .busy(busy), .txd_o(txd_o), .rxd_o(rxd_o), .rxd_oe(rxd_oe)
);

// File: tb/test_dual_serial_port.sv
`timescale 1ns/1ps
module test_dual_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sync = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_req = 1'b0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_overrun, busy, txd_o, rxd_o, rxd_oe;
  logic       rxd_i = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dual_serial_port i_dual_serial_port (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .baud_tick(baud_tick),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_req(rx_req), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .busy(busy), .txd_o(txd_o), .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe)
  );

  // baud tick: one cycle in four, so one async bit = 64 clocks
  initial begin
    forever begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        baud_tick = (k == 3);
      end
    end
  end

  // {sync mode, transmit, byte}
  localparam logic [9:0] VEC [0:7] = '{
    {2'b01, 8'h5A}, {2'b01, 8'h81}, {2'b00, 8'h3C}, {2'b00, 8'hFE},
    {2'b11, 8'hA7}, {2'b11, 8'h01}, {2'b10, 8'hC6}, {2'b10, 8'h00}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic req_rx();
    @(negedge clk); rx_req = 1'b1;
    @(negedge clk); rx_req = 1'b0;
  endtask

  task automatic rd_byte();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic async_tx_check(input logic [7:0] b, input bit poke);
    logic [7:0] got = 8'h00;
    wr_byte(b);
    for (int n = 0; n < 200 && txd_o !== 1'b0; n++) @(negedge clk);
    repeat (32) @(negedge clk);
    chk(txd_o == 1'b0, "R2 start bit", txd_o, 0);
    chk(rxd_oe == 1'b0, "R9 oe in async", rxd_oe, 0);
    if (poke) wr_byte(~b);   // R11: ignored while busy
    for (int i = 0; i < 8; i++) begin
      repeat (poke && i == 0 ? 62 : 64) @(negedge clk);
      got[i] = txd_o;
    end
    chk(got == b, "R2 data bits", got, b);
    repeat (64) @(negedge clk);
    chk(txd_o == 1'b1 && busy, "R2 stop bit", {busy, txd_o}, 2'b11);
    wait_idle();
  endtask

  task automatic async_rx_send(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd_i = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (64) @(negedge clk);
    end
    rxd_i = stop;
    repeat (64) @(negedge clk);
    rxd_i = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic sync_tx_check(input logic [7:0] b);
    int rises = 0, lows = 0, last = 0, cyc = 0;
    logic prev = 1'b1;
    logic [7:0] got = 8'h00;
    wr_byte(b);
    while (rises < 8 && cyc < 200) begin
      @(negedge clk); cyc++;
      if (!txd_o) lows++;
      if (!prev && txd_o) begin
        got[rises] = rxd_o;
        if (rises > 0) chk(cyc - last == 8, "R6 period", cyc - last, 8);
        chk(rxd_oe == 1'b1, "R9 oe in sync tx", rxd_oe, 1);
        last = cyc;
        rises++;
      end
      prev = txd_o;
    end
    chk(got == b, "R7 sync data", got, b);
    chk(lows == 32, "R6 low phases", lows, 32);
    wait_idle();
    @(negedge clk);
    chk(txd_o == 1'b1 && rxd_oe == 1'b0, "R6 idle clock", {txd_o, rxd_oe}, 2'b10);
  endtask

  task automatic sync_rx_run(input logic [7:0] b);
    int rises = 0, cyc = 0;
    logic prev = 1'b1;
    @(negedge clk); rxd_i = b[0];
    req_rx();
    while (rises < 8 && cyc < 200) begin
      @(negedge clk); cyc++;
      if (rxd_oe) chk(1'b0, "R8 line released", rxd_oe, 0);
      if (!prev && txd_o) begin
        rises++;
        if (rises < 8) rxd_i = b[rises];
      end
      prev = txd_o;
    end
    chk(rises == 8, "R8 clock count", rises, 8);
    wait_idle();
    @(negedge clk);
    rxd_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd_o == 1'b1 && !rxd_oe && !busy && !rx_ready && !rx_overrun,
        "R1 reset state", {txd_o, rxd_oe, busy, rx_ready, rx_overrun}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); mode_sync = VEC[i][9];
      repeat (2) @(negedge clk);
      if (!VEC[i][9] && VEC[i][8]) async_tx_check(VEC[i][7:0], 1'b0);
      else if (!VEC[i][9]) begin
        async_rx_send(VEC[i][7:0], 1'b1);
        chk(rx_ready && rx_data == VEC[i][7:0], "R3 async receive", {rx_ready, rx_data}, {1'b1, VEC[i][7:0]});
        rd_byte();
        chk(!rx_ready, "R10 read clears", rx_ready, 0);
      end
      else if (VEC[i][8]) sync_tx_check(VEC[i][7:0]);
      else begin
        sync_rx_run(VEC[i][7:0]);
        chk(rx_ready && rx_data == VEC[i][7:0], "R8 sync receive", {rx_ready, rx_data}, {1'b1, VEC[i][7:0]});
        rd_byte();
      end
    end

    // R11: write while busy is dropped, no second frame follows
    @(negedge clk); mode_sync = 1'b0;
    repeat (2) @(negedge clk);
    async_tx_check(8'hC3, 1'b1);
    repeat (100) @(negedge clk);
    chk(!busy && txd_o, "R11 busy write ignored", {busy, txd_o}, 2'b01);

    // R11: receive request ignored in async mode
    req_rx();
    chk(!busy && txd_o && !rxd_oe, "R11 rx_req in async", {busy, txd_o, rxd_oe}, 3'b010);

    // R4: short low glitch
    @(negedge clk); rxd_i = 1'b0;
    repeat (8) @(negedge clk); rxd_i = 1'b1;
    repeat (700) @(negedge clk);
    chk(!rx_ready, "R4 false start", rx_ready, 0);

    // R5: bad stop bit
    async_rx_send(8'hA5, 1'b0);
    repeat (100) @(negedge clk);
    chk(!rx_ready && rx_data == 8'h00, "R5 framing drop", {rx_ready, rx_data}, 9'h000);

    // R10: overrun keeps old byte, read clears both
    @(negedge clk); mode_sync = 1'b1;
    repeat (2) @(negedge clk);
    sync_rx_run(8'h96);
    sync_rx_run(8'h3B);
    chk(rx_ready && rx_overrun && rx_data == 8'h96, "R10 overrun",
        {rx_ready, rx_overrun, rx_data}, {2'b11, 8'h96});
    rd_byte();
    chk(!rx_ready && !rx_overrun, "R10 read clears flags", {rx_ready, rx_overrun}, 2'b00);

    // R1: reset in the middle of a sync transmit
    wr_byte(8'hF0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && txd_o && !rxd_oe, "R1 mid-transfer reset", {busy, txd_o, rxd_oe}, 3'b010);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule